// File: doc/BRIEF.md
# Key-Gated System Configuration Register Block

This block is a small system-control register file on a simple 32-bit register bus. It holds a device-configuration register whose bits drive enables elsewhere in the chip. Bit 23 enables the coprocessor. Bit 31 requests a chip reset. Writes to the configuration register are protected by a single-shot key. A key word written to the lock register opens exactly one following bus write, and the block then locks again. Every protected write therefore needs its own key write.

The lock is a two-state machine with the states `LK_LOCKED` and `LK_OPEN`. It has four named transitions:

- **UNLOCK** (`LK_LOCKED` to `LK_OPEN`): a write of the key word to the lock register.
- **REARM** (`LK_OPEN` to `LK_OPEN`): a further key write while the lock is open.
- **CONSUME** (`LK_OPEN` to `LK_LOCKED`): any other bus write, to any address, while the lock is open.
- **HOLD**: any cycle with no bus write, and any non-key write while locked. The state does not change.

To request a chip reset, software writes the key and sets bit 31. It then writes the key again and clears bit 31. The reset request output is high between these two writes, so external reset logic sees it as a pulse.

Top module: `syslock_ctrl`

## Requirements
- R1: After reset the lock is locked and the configuration register reads 0. The lock register reads 0, and `coproc_en` and `reset_req` are low.
- R2: A write of exactly 0x0000_00AA to offset 0xC0 opens the lock. From the next cycle, reading offset 0xC0 returns 1.
- R3: A write to offset 0xC0 of any value other than 0x0000_00AA leaves the lock locked. This includes values whose low byte is 0xAA and whose upper bits are not zero.
- R4: A write to offset 0x80 while the lock is locked has no effect on the configuration register.
- R5: A write to offset 0x80 while the lock is open loads the full 32-bit word into the register. The lock is locked from the next cycle.
- R6: Two configuration writes in a row after a single key write: the first is accepted and the second is ignored.
- R7: A bus write to any address other than 0xC0 or 0x80 while the lock is open consumes the unlock.
- R8: Reads never change the lock state or the configuration register. Offset 0x80 reads the register whether the lock is open or locked, and unmapped offsets read 0.
- R9: `coproc_en` equals bit 23 of the configuration register.
- R10: `reset_req` equals bit 31 of the configuration register. A set write followed by a clear write, each after its own key, yields a pulse on `reset_req`.
- R11: A key write while the lock is open keeps it open, and still only one non-key write is allowed after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 8 | Byte offset for the read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| dev_cfg | output | 32 | Device-configuration register contents |
| coproc_en | output | 1 | Coprocessor access enable (bit 23) |
| reset_req | output | 1 | Chip reset request (bit 31) |

## Verification
On every cycle, the assertions check the following lock transitions and register update rules:

- UNLOCK and REARM open the lock, and every other write locks it.
- The configuration register holds its value through locked writes and through idle cycles.
- An open write loads the configuration register with the written word.

The bench covers what needs a chosen history:

- It sweeps all low-byte key values.
- It sweeps every bus offset as the consuming write.
- It runs the back-to-back protected write case and the set-then-clear reset pulse.
- It reads back through the read mux in both lock states.

// File: rtl/syslock_pkg.sv
package syslock_pkg;
    typedef enum logic {
        LK_LOCKED = 1'b0,
        LK_OPEN   = 1'b1
    } lock_st_t;
endpackage

// File: rtl/syslock_fsm.sv
module syslock_fsm
    import syslock_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_any,
    input  logic wr_key,
    output logic lock_open
);
    lock_st_t st_q, st_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= LK_LOCKED;
        else        st_q <= st_d;
    end

    // transitions: UNLOCK, REARM, CONSUME, HOLD
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            LK_LOCKED: if (wr_key) st_d = LK_OPEN;
            LK_OPEN: begin
                if (wr_key)      st_d = LK_OPEN;
                else if (wr_any) st_d = LK_LOCKED;
            end
            default: st_d = LK_LOCKED;
        endcase
    end

    // outputs
    always_comb begin
        unique case (st_q)
            LK_OPEN:   lock_open = 1'b1;
            LK_LOCKED: lock_open = 1'b0;
            default:   lock_open = 1'b0;
        endcase
    end
endmodule

// File: rtl/syslock_cfg_reg.sv
module syslock_cfg_reg #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= '0;
        else if (we) q <= wdata;
    end
endmodule

// File: rtl/syslock_decode.sv
module syslock_decode #(
    parameter int                ADDR_W   = 8,
    parameter int                DATA_W   = 32,
    parameter logic [ADDR_W-1:0] LOCK_OFS = 8'hC0,
    parameter logic [ADDR_W-1:0] CFG_OFS  = 8'h80
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              lock_open,
    input  logic [DATA_W-1:0] cfg_q,
    output logic              hit_lock,
    output logic              hit_cfg,
    output logic [DATA_W-1:0] rdata
);
    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    assign hit_lock = (addr == LOCK_OFS);
    assign hit_cfg  = (addr == CFG_OFS);

    always_comb begin
        if (hit_lock)     rdata = lock_open ? ONE : '0;
        else if (hit_cfg) rdata = cfg_q;
        else              rdata = '0;
    end
endmodule

// File: rtl/syslock_ctrl.sv
module syslock_ctrl #(
    parameter int                ADDR_W    = 8,
    parameter int                DATA_W    = 32,
    parameter logic [ADDR_W-1:0] LOCK_OFS  = 8'hC0,
    parameter logic [ADDR_W-1:0] CFG_OFS   = 8'h80,
    parameter logic [DATA_W-1:0] KEY       = 32'h0000_00AA,
    parameter int                COPRO_BIT = 23,
    parameter int                RESET_BIT = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] dev_cfg,
    output logic              coproc_en,
    output logic              reset_req
);
    logic lock_open;
    logic hit_lock, hit_cfg;
    logic wr_key, cfg_we;

    assign wr_key = bus_wr && hit_lock && (bus_wdata == KEY);
    assign cfg_we = bus_wr && hit_cfg && lock_open;

    syslock_decode #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .LOCK_OFS(LOCK_OFS), .CFG_OFS(CFG_OFS)
    ) u_dec (
        .addr(bus_addr), .lock_open(lock_open), .cfg_q(dev_cfg),
        .hit_lock(hit_lock), .hit_cfg(hit_cfg), .rdata(bus_rdata)
    );

    syslock_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .wr_any(bus_wr), .wr_key(wr_key),
        .lock_open(lock_open)
    );

    syslock_cfg_reg #(.DATA_W(DATA_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(bus_wdata), .q(dev_cfg)
    );

    assign coproc_en = dev_cfg[COPRO_BIT];
    assign reset_req = dev_cfg[RESET_BIT];
endmodule

// File: rtl/syslock_ctrl_chk.sv
module syslock_ctrl_chk #(
    parameter int                ADDR_W   = 8,
    parameter int                DATA_W   = 32,
    parameter logic [ADDR_W-1:0] LOCK_OFS = 8'hC0,
    parameter logic [ADDR_W-1:0] CFG_OFS  = 8'h80,
    parameter logic [DATA_W-1:0] KEY      = 32'h0000_00AA
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] dev_cfg,
    input logic              lock_open
);
    logic key_w;
    assign key_w = bus_wr && (bus_addr == LOCK_OFS) && (bus_wdata == KEY);

    AST_KEY_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        key_w |=> lock_open);                                        // R2
    AST_OTHER_WRITE_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !key_w) |=> !lock_open);                          // R7
    AST_LOCKED_CFG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == CFG_OFS && !lock_open) |=> $stable(dev_cfg)); // R4
    AST_OPEN_CFG_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == CFG_OFS && lock_open) |=> (dev_cfg == $past(bus_wdata))); // R5
    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> ($stable(lock_open) && $stable(dev_cfg)));       // R8
endmodule

bind syslock_ctrl syslock_ctrl_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .LOCK_OFS(LOCK_OFS), .CFG_OFS(CFG_OFS), .KEY(KEY)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .dev_cfg(dev_cfg), .lock_open(lock_open)
);

// File: tb/syslock_ctrl_test.sv
`timescale 1ns/1ps
module syslock_ctrl_test;
    localparam logic [7:0]  LOCK = 8'hC0;
    localparam logic [7:0]  CFG  = 8'h80;
    localparam logic [31:0] KEYW = 32'h0000_00AA;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata, dev_cfg;
    logic        coproc_en, reset_req;

    int checks = 0;
    int errors = 0;
    logic [31:0] m_cfg = '0;
    logic        m_open = 1'b0;
    logic        saw_rst_pulse;

    always #4 clk = ~clk;

    syslock_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dev_cfg(dev_cfg),
        .coproc_en(coproc_en), .reset_req(reset_req)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one bus write; model updated from the requirements
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        if (a == CFG && m_open) m_cfg = d;
        m_open = (a == LOCK && d == KEYW);
    endtask

    task automatic check_all(input string req);
        bus_addr = LOCK; #1;
        chk(bus_rdata == {31'b0, m_open}, {req, " lock read"}, bus_rdata, {31'b0, m_open});
        bus_addr = CFG; #1;
        chk(bus_rdata == m_cfg, {req, " cfg read R8"}, bus_rdata, m_cfg);
        chk(dev_cfg == m_cfg, {req, " dev_cfg"}, dev_cfg, m_cfg);
        chk(coproc_en == m_cfg[23], "R9 coproc_en", {31'b0, coproc_en}, {31'b0, m_cfg[23]});
        chk(reset_req == m_cfg[31], "R10 reset_req", {31'b0, reset_req}, {31'b0, m_cfg[31]});
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    always @(posedge clk) if (reset_req) saw_rst_pulse <= 1'b1;

    initial begin
        saw_rst_pulse = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_all("R1");

        // R4: locked write ignored
        wr(CFG, 32'hDEAD_BEEF);
        check_all("R4");

        // R2/R3: sweep every low-byte value on the lock register, then a cfg write
        for (int i = 0; i < 256; i++) begin
            wr(LOCK, 32'(i));
            check_all(i == 'hAA ? "R2" : "R3");
            wr(CFG, 32'h0100_0000 | 32'(i));
            check_all(i == 'hAA ? "R5" : "R4");
        end
        // R3: low byte matches but upper bits set
        wr(LOCK, 32'h0000_01AA);
        check_all("R3");
        wr(CFG, 32'h1234_5678);
        check_all("R3");

        // R7: every offset used as the consuming write after a key
        for (int a = 0; a < 256; a++) begin
            wr(LOCK, KEYW);
            wr(8'(a), 32'h5A00_0000 | 32'(a));
            check_all(8'(a) == LOCK ? "R3" : (8'(a) == CFG ? "R5" : "R7"));
            wr(CFG, 32'h00C0_0000 | 32'(a));
            check_all("R7");
            bus_addr = 8'(a) ^ 8'h01; #1;
            if ((8'(a) ^ 8'h01) != LOCK && (8'(a) ^ 8'h01) != CFG)
                chk(bus_rdata == 32'h0, "R8 unmapped read", bus_rdata, 32'h0);
        end

        // R6: two protected writes after one key
        wr(LOCK, KEYW);
        wr(CFG, 32'h0080_0001);
        wr(CFG, 32'h0000_0002);
        check_all("R6");
        chk(dev_cfg == 32'h0080_0001, "R6 second write ignored", dev_cfg, 32'h0080_0001);

        // R11: rearm keeps open, still single-shot
        wr(LOCK, KEYW);
        wr(LOCK, KEYW);
        check_all("R11");
        wr(CFG, 32'h0000_0003);
        wr(CFG, 32'h0000_0004);
        check_all("R11");
        chk(dev_cfg == 32'h0000_0003, "R11 value", dev_cfg, 32'h0000_0003);

        // R8: idle reads while open do not consume
        wr(LOCK, KEYW);
        repeat (5) begin
            @(negedge clk);
            bus_addr = CFG; #1;
            bus_addr = LOCK; #1;
        end
        check_all("R8");
        wr(CFG, 32'h0000_0005);
        check_all("R8");

        // R10: reset request pulse, set then clear with two keys
        saw_rst_pulse = 1'b0;
        wr(LOCK, KEYW);
        wr(CFG, m_cfg | 32'h8000_0000);
        check_all("R10");
        wr(LOCK, KEYW);
        wr(CFG, m_cfg & ~32'h8000_0000);
        check_all("R10");
        chk(saw_rst_pulse == 1'b1, "R10 pulse seen", {31'b0, saw_rst_pulse}, 32'h1);

        // R1: reset again clears state
        wr(LOCK, KEYW);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        m_cfg = '0; m_open = 1'b0;
        check_all("R1");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule